// File: doc/BRIEF.md
# Soft Interrupt Register with Priority-Level Masking

This block keeps one strand's software interrupt bits together with its current processor interrupt level (PIL), and turns the two into a vector of level-sensitive interrupt requests. Software updates the bit register through a single write port. A two-bit selector on that port picks one of three operations: a plain overwrite, an OR-in through a set alias, or an AND with the complement of the data through a clear alias. The PIL has its own write strobe and can change in any cycle.

Two hardware strobes from timer compare logic also set bits. The tick match sets bit 0 and the system-tick match sets bit 16. Both go through the same next-value path as software writes. A bit in the range 1 to 15 requests an interrupt only when its own index is above the PIL. Bits 0 and 16 have a fixed threshold and request only while the PIL is below 14. The request vector is derived from registered state, so it follows any update one clock edge after that update is presented. Arbitration among requests and trap delivery belong to downstream logic.

Top module: `softint_pil_unit`

## Requirements
- R1: After reset the bit register, the PIL and every request output are zero.
- R2: A write with selector 2'b00 replaces the 17-bit register with the write data at the next clock edge.
- R3: A write with selector 2'b01 ORs the write data into the register.
- R4: A write with selector 2'b10 clears every register bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A write with selector 2'b11 leaves the register unchanged.
- R6: Request bits 0 and 16 are high exactly when the matching register bit is set and the PIL is less than 14.
- R7: For each n from 1 to 15, request bit n is high exactly when register bit n is set and n is strictly greater than the PIL.
- R8: A PIL write loads the 4-bit PIL at the next edge, and the request vector reflects the new level in that same cycle. It may coincide with a register write, and both then take effect.
- R9: The tick-match strobe sets bit 0 and the system-tick-match strobe sets bit 16. A strobe wins over a clear or overwrite of the same bit in the same cycle.
- R10: The read output always shows the current register value, whichever alias was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 direct, 01 set alias, 10 clear alias, 11 reserved |
| wr_data | input | 17 | Write data |
| pil_wr | input | 1 | PIL write strobe |
| pil_data | input | 4 | New PIL value |
| tick_match | input | 1 | Timer match, sets bit 0 |
| stick_match | input | 1 | System-tick match, sets bit 16 |
| rd_data | output | 17 | Current register value |
| pil_q | output | 4 | Current PIL |
| irq_req | output | 17 | Masked request vector |

## Verification
A hardware match strobe can arrive in the same cycle as a software clear or overwrite that removes the same bit. The random stimulus raises both strobes independently of the write port, and directed cases line up a clear of bit 0 and bit 16 with their strobes. The bench model applies the software operation first and then ORs in the strobes, and it expects the bit to remain set. A PIL write that coincides with a register write is also judged: the requests must match the new bits masked by the new level.

// File: rtl/softint_pkg.sv
package softint_pkg;
    typedef enum logic [1:0] {
        SEL_DIRECT = 2'b00,
        SEL_SET    = 2'b01,
        SEL_CLEAR  = 2'b10,
        SEL_RSVD   = 2'b11
    } wr_sel_e;
endpackage

// File: rtl/softint_next.sv
module softint_next #(
    parameter int NUM_BITS = 17
) (
    input  logic [NUM_BITS-1:0]  cur,
    input  logic                 wr_en,
    input  softint_pkg::wr_sel_e wr_sel,
    input  logic [NUM_BITS-1:0]  wr_data,
    input  logic [NUM_BITS-1:0]  hw_set,
    output logic [NUM_BITS-1:0]  nxt
);
    import softint_pkg::*;
    logic [NUM_BITS-1:0] sw_val;

    always_comb begin
        sw_val = cur;
        if (wr_en) begin
            case (wr_sel)
                SEL_DIRECT: sw_val = wr_data;
                SEL_SET:    sw_val = cur | wr_data;
                SEL_CLEAR:  sw_val = cur & ~wr_data;
                default:    sw_val = cur;
            endcase
        end
        // hardware strobes are applied last so they override software
        nxt = sw_val | hw_set;
    end
endmodule

// File: rtl/softint_mask.sv
module softint_mask #(
    parameter int NUM_BITS  = 17,
    parameter int PIL_W     = 4,
    parameter int EDGE_GATE = 14
) (
    input  logic [NUM_BITS-1:0] bits,
    input  logic [PIL_W-1:0]    pil,
    output logic [NUM_BITS-1:0] req
);
    localparam int TOP = NUM_BITS - 1;

    logic edge_open;
    assign edge_open = (32'(pil) < EDGE_GATE);

    for (genvar n = 0; n < NUM_BITS; n++) begin : g_bit
        if (n == 0 || n == TOP) begin : g_edge
            assign req[n] = bits[n] & edge_open;
        end else begin : g_level
            assign req[n] = bits[n] & (n > 32'(pil));
        end
    end
endmodule

// File: rtl/softint_pil_unit.sv
module softint_pil_unit #(
    parameter int NUM_BITS  = 17,
    parameter int PIL_W     = 4,
    parameter int EDGE_GATE = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [NUM_BITS-1:0] wr_data,
    input  logic                pil_wr,
    input  logic [PIL_W-1:0]    pil_data,
    input  logic                tick_match,
    input  logic                stick_match,
    output logic [NUM_BITS-1:0] rd_data,
    output logic [PIL_W-1:0]    pil_q,
    output logic [NUM_BITS-1:0] irq_req
);
    import softint_pkg::*;
    localparam int TOP = NUM_BITS - 1;

    typedef struct packed {
        logic [NUM_BITS-1:0] bits;
        logic [PIL_W-1:0]    pil;
    } state_t;

    state_t state_d, state_q;
    logic [NUM_BITS-1:0] hw_set;
    logic [NUM_BITS-1:0] bits_nxt;

    always_comb begin
        hw_set      = '0;
        hw_set[0]   = tick_match;
        hw_set[TOP] = stick_match;
    end

    softint_next #(.NUM_BITS(NUM_BITS)) u_next (
        .cur     (state_q.bits),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .hw_set  (hw_set),
        .nxt     (bits_nxt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.bits = bits_nxt;
        if (pil_wr) state_d.pil = pil_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    softint_mask #(.NUM_BITS(NUM_BITS), .PIL_W(PIL_W), .EDGE_GATE(EDGE_GATE)) u_mask (
        .bits (state_q.bits),
        .pil  (state_q.pil),
        .req  (irq_req)
    );

    assign rd_data = state_q.bits;
    assign pil_q   = state_q.pil;
endmodule

// File: rtl/softint_pil_unit_chk.sv
module softint_pil_unit_chk #(
    parameter int NUM_BITS = 17,
    parameter int PIL_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic [NUM_BITS-1:0] wr_data,
    input logic                pil_wr,
    input logic [PIL_W-1:0]    pil_data,
    input logic                tick_match,
    input logic                stick_match,
    input logic [NUM_BITS-1:0] rd_data,
    input logic [PIL_W-1:0]    pil_q,
    input logic [NUM_BITS-1:0] irq_req
);
    localparam int TOP = NUM_BITS - 1;

    p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b01) |=> ((rd_data & $past(wr_data)) == $past(wr_data)));

    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b10 && !tick_match && !stick_match) |=> ((rd_data & $past(wr_data)) == '0));

    p_rsvd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11 && !tick_match && !stick_match) |=> $stable(rd_data));

    p_edge_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pil_q >= PIL_W'(14)) |-> (!irq_req[0] && !irq_req[TOP]));

    p_req_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~rd_data) == '0));

    p_pil_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pil_wr |=> (pil_q == $past(pil_data)));

    p_tick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_match |=> rd_data[0]);

    p_stick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stick_match |=> rd_data[TOP]);
endmodule

bind softint_pil_unit softint_pil_unit_chk #(.NUM_BITS(NUM_BITS), .PIL_W(PIL_W)) u_chk (.*);

// File: tb/sim_softint_pil_unit.sv
module sim_softint_pil_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [16:0] wr_data = '0;
    logic        pil_wr = 1'b0;
    logic [3:0]  pil_data = '0;
    logic        tick_match = 1'b0;
    logic        stick_match = 1'b0;
    logic [16:0] rd_data;
    logic [3:0]  pil_q;
    logic [16:0] irq_req;

    int checks = 0;
    int fails  = 0;
    logic [16:0] m_bits = '0;
    logic [3:0]  m_pil  = '0;

    always #10 clk = ~clk;

    softint_pil_unit u0 (.*);

    function automatic logic [16:0] exp_req(input logic [16:0] b, input logic [3:0] p);
        logic [16:0] r;
        r = '0;
        for (int n = 1; n < 16; n++) r[n] = b[n] && (n > int'(p));
        r[0]  = b[0]  && (p < 4'd14);
        r[16] = b[16] && (p < 4'd14);
        return r;
    endfunction

    function automatic logic [16:0] exp_bits(input logic [16:0] cur, input logic en,
            input logic [1:0] sel, input logic [16:0] d, input logic t, input logic s);
        logic [16:0] v;
        v = cur;
        if (en) begin
            if (sel == 2'b00) v = d;
            else if (sel == 2'b01) v = cur | d;
            else if (sel == 2'b10) v = cur & ~d;
        end
        v[0]  = v[0] | t;
        v[16] = v[16] | s;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic [1:0] sel, input logic [16:0] d,
            input logic pw, input logic [3:0] pd, input logic t, input logic s, input string req);
        wr_en = en; wr_sel = sel; wr_data = d; pil_wr = pw; pil_data = pd;
        tick_match = t; stick_match = s;
        @(posedge clk);
        m_bits = exp_bits(m_bits, en, sel, d, t, s);
        if (pw) m_pil = pd;
        @(negedge clk);
        wr_en = 1'b0; pil_wr = 1'b0; tick_match = 1'b0; stick_match = 1'b0;
        check({req, " R10 rd"}, 32'(rd_data), 32'(m_bits));
        check({req, " R8 pil"}, 32'(pil_q), 32'(m_pil));
        check({req, " R6/R7 irq"}, 32'(irq_req), 32'(exp_req(m_bits, m_pil)));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset bits", 32'(rd_data), 0);
        check("R1 reset pil", 32'(pil_q), 0);
        check("R1 reset irq", 32'(irq_req), 0);
        // R2 direct write, R6 edge bits at pil 0
        step(1, 2'b00, 17'h1FFFF, 0, 4'd0, 0, 0, "R2 direct all");
        // R6 boundary 13 vs 14
        step(0, 2'b00, '0, 1, 4'd13, 0, 0, "R6 pil13");
        check("R6 bit0 open at 13", 32'(irq_req[0]), 1);
        step(0, 2'b00, '0, 1, 4'd14, 0, 0, "R6 pil14");
        check("R6 bit16 shut at 14", 32'(irq_req[16]), 0);
        check("R7 bit15 open at 14", 32'(irq_req[15]), 1);
        step(0, 2'b00, '0, 1, 4'd15, 0, 0, "R7 pil15");
        check("R7 none at 15", 32'(irq_req), 0);
        // R4 clear alias
        step(1, 2'b10, 17'h0FFFE, 1, 4'd0, 0, 0, "R4 clear mid");
        check("R4 only edges left", 32'(rd_data), 32'h10001);
        // R9 clear collides with strobes
        step(1, 2'b10, 17'h1FFFF, 0, 4'd0, 1, 1, "R9 clear vs hw");
        check("R9 hw wins clear", 32'(rd_data), 32'h10001);
        step(1, 2'b00, 17'h00000, 0, 4'd0, 0, 1, "R9 direct vs stick");
        check("R9 hw wins direct", 32'(rd_data), 32'h10000);
        // R3 set alias, R7 n equal to pil
        step(1, 2'b01, 17'h00022, 1, 4'd5, 0, 0, "R3 set");
        check("R7 bit5 at pil5 off", 32'(irq_req[5]), 0);
        check("R7 bit1 at pil5 off", 32'(irq_req[1]), 0);
        // R5 reserved code
        step(1, 2'b11, 17'h1FFFF, 0, 4'd0, 0, 0, "R5 rsvd");
        check("R5 unchanged", 32'(rd_data), 32'h10022);
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[2:1], 17'($urandom), r[3], r[7:4], r[8] & r[9], r[10] & r[11], "rand");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule